// File: doc/BRIEF.md
# I2C Bus Event Status Unit

This block sits beside an I2C controller and turns what happens on the wire into a small read-only status byte. It samples the SCL and SDA lines through synchronizers, recognises Start and Stop conditions and rising SCL edges, and combines them with the bit-phase hints the controller supplies. From these it keeps five sticky flags: missing acknowledge, Stop seen as a slave, arbitration lost, misplaced Start/Stop and general call. The byte shifter, the clock generator and address matching stay in the controller. This unit only watches the bus and reports.

A single interrupt request is raised while any flag is set and interrupts are enabled. Software clears all flags by reading the byte; the controller pulses `rd_stb` in the cycle the read is taken. Dropping the peripheral enable wipes every flag. The unit also holds the master/slave mode bit. The controller requests master mode and releases it, and a lost arbitration returns the unit to slave on its own. None of these flags asks for SCL to be held low, so the unit has no clock-stretch output.

Top module: `i2c_evt_status`

## Requirements
- R1: After reset `status` reads 8'h00, `irq` is 0 and `master_mode` is 0; bits 7 to 5 of `status` always read 0.
- R2: Flag positions in `status`: bit 4 missing acknowledge, bit 3 slave Stop, bit 2 arbitration lost, bit 1 bus error, bit 0 general call.
- R3: When a rising SCL edge falls in the acknowledge slot (`ack_slot`=1) while transmitting (`is_tx`=1) and SDA is high, bit 4 sets. It is visible three clock edges after the SCL input rises, and not after two.
- R4: A Stop (SDA rising while SCL is high) sets bit 3 only in slave mode with `ack_en`=1 and after an acknowledge was seen. An acknowledge is SDA low at a rising SCL edge in the acknowledge slot. No flag sets with `ack_en`=0 or in master mode.
- R5: In master mode, while transmitting a data bit (`byte_phase`=1, `is_tx`=1) with `drv_sda`=1, a rising SCL edge that samples SDA low sets bit 2 and clears `master_mode` in the same edge.
- R6: In master-receive mode (`is_tx`=0) the acknowledge slot is never compared, so SDA low against `drv_sda`=1 there sets no flag and keeps `master_mode` at 1.
- R7: A Start (SDA falling while SCL is high) or a Stop that occurs while `byte_phase`=1 sets bit 1.
- R8: A `gcall_hit` pulse in slave mode sets bit 0 at the next clock edge.
- R9: A `rd_stb` cycle clears every flag. A flag whose event arrives in that same cycle is set after the edge.
- R10: With `periph_en`=0 all flags and `master_mode` are 0 from the next edge, and no event or `mst_req` sets them.
- R11: `irq` is 1 exactly when `irq_en`=1 and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| periph_en | input | 1 | Peripheral enable; low clears flags and mode |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge generation enabled |
| mst_req | input | 1 | Controller enters master mode |
| mst_rel | input | 1 | Controller leaves master mode |
| drv_sda | input | 1 | SDA level the controller is driving |
| byte_phase | input | 1 | Inside the eight data bits of a byte |
| ack_slot | input | 1 | Inside the ninth (acknowledge) bit |
| is_tx | input | 1 | Controller is the transmitter |
| gcall_hit | input | 1 | General call address matched |
| rd_stb | input | 1 | Status byte is being read |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| master_mode | output | 1 | 1 = master, 0 = slave |

## Verification
The read-clear and a new flag event can land in the same clock cycle. The unit must then drop the flags that were read and keep the one just raised. The bench provokes this with a bus error already latched, then pulses `rd_stb` and `gcall_hit` together. It expects exactly the general-call bit afterwards. A second case raises the general call alone under a read strobe. A further pair puts arbitration loss against master mode in one edge: the flag must appear at the same edge that `master_mode` falls.

// File: rtl/i2c_evt_pkg.sv
// Package: flag positions and widths shared by the status unit.
// Assumes the status byte is eight bits with flags packed from bit 0.
package i2c_evt_pkg;
    localparam int STATUS_W = 8;
    localparam int NFLAG    = 5;
    localparam int BIT_GC   = 0;
    localparam int BIT_BERR = 1;
    localparam int BIT_ARB  = 2;
    localparam int BIT_STOP = 3;
    localparam int BIT_AF   = 4;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-stage synchronizer for one asynchronous line.
// Assumes the line idles at RST_VAL (a released I2C line reads 1).
module i2c_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // one flop of the chain, first stage takes the raw line
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[g] <= RST_VAL;
            else if (g == 0)
                chain[g] <= d;
            else
                chain[g] <= chain[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
// Module: detects Start, Stop and rising SCL from synchronized lines.
// Assumes both inputs are already synchronous; idle bus is both high.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic start_c,
    output logic stop_c
);
    logic scl_d, sda_d;

    // hold the previous sample of each line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // classify the edges; SDA edges count only with SCL high on both samples
    always_comb begin
        scl_rise = scl_s && !scl_d;
        start_c  = scl_s && scl_d && sda_d && !sda_s;
        stop_c   = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/i2c_flag_bank.sv
// Module: sticky flag registers with clear-on-read and enable clear.
// Assumes set pulses last one cycle; a set wins over a same-cycle read.
module i2c_flag_bank #(
    parameter int NF = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rd_stb,
    input  logic [NF-1:0] set_vec,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        // one flag: cleared when disabled, else set beats read-clear
        always_ff @(posedge clk) begin
            if (!rst_n || !en)
                flags[i] <= 1'b0;
            else
                flags[i] <= set_vec[i] | (flags[i] & ~rd_stb);
        end
    end

    // R9: a read with no event empties the bank
    assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_stb && set_vec == '0) |=> (flags == '0));

    // R9: an event raised under a read is still present afterwards
    assert_event_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R10: disabling the peripheral empties the bank
    assert_disable_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (flags == '0));
endmodule

// File: rtl/i2c_evt_status.sv
// Module: top of the I2C bus event status unit. Decodes bus events into
// flag set pulses, holds the master/slave mode bit and the interrupt.
// Assumes the controller supplies bit-phase hints aligned with SCL.
module i2c_evt_status
    import i2c_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                periph_en,
    input  logic                irq_en,
    input  logic                ack_en,
    input  logic                mst_req,
    input  logic                mst_rel,
    input  logic                drv_sda,
    input  logic                byte_phase,
    input  logic                ack_slot,
    input  logic                is_tx,
    input  logic                gcall_hit,
    input  logic                rd_stb,
    output logic [STATUS_W-1:0] status,
    output logic                irq,
    output logic                master_mode
);
    localparam int PAD_W = STATUS_W - NFLAG;

    logic scl_s, sda_s;
    logic scl_rise, start_c, stop_c;
    logic ack_seen;
    logic af_evt, arb_evt, stop_evt, berr_evt, gc_evt;
    logic [NFLAG-1:0] set_vec, flags;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    i2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .start_c(start_c), .stop_c(stop_c));

    // remember whether the last acknowledge slot carried an ACK
    always_ff @(posedge clk) begin
        if (!rst_n || !periph_en)
            ack_seen <= 1'b0;
        else if (start_c || stop_c)
            ack_seen <= 1'b0;
        else if (scl_rise && ack_slot && !sda_s)
            ack_seen <= 1'b1;
    end

    // decode bus and controller events into flag set pulses
    always_comb begin
        af_evt   = scl_rise && ack_slot && is_tx && sda_s;
        arb_evt  = scl_rise && master_mode && byte_phase && is_tx
                   && drv_sda && !sda_s;
        stop_evt = stop_c && !master_mode && ack_en && ack_seen;
        berr_evt = (start_c || stop_c) && byte_phase;
        gc_evt   = gcall_hit && !master_mode;
        set_vec           = '0;
        set_vec[BIT_AF]   = af_evt;
        set_vec[BIT_STOP] = stop_evt;
        set_vec[BIT_ARB]  = arb_evt;
        set_vec[BIT_BERR] = berr_evt;
        set_vec[BIT_GC]   = gc_evt;
    end

    // master/slave mode bit: lost arbitration forces slave
    always_ff @(posedge clk) begin
        if (!rst_n || !periph_en)
            master_mode <= 1'b0;
        else if (arb_evt || mst_rel)
            master_mode <= 1'b0;
        else if (mst_req)
            master_mode <= 1'b1;
    end

    i2c_flag_bank #(.NF(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .en(periph_en), .rd_stb(rd_stb),
        .set_vec(set_vec), .flags(flags));

    // assemble the status byte and the interrupt request
    always_comb begin
        status = {{PAD_W{1'b0}}, flags};
        irq    = irq_en && (flags != '0);
    end

    // R5: arbitration flag appears together with return to slave
    assert_arb_slave_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_ARB]) |-> !master_mode);

    // R4: slave Stop flag only rises from slave mode with ack enabled
    assert_stop_slave_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_STOP]) |-> $past(!master_mode && ack_en));

    // R10: mode bit is slave one edge after disable
    assert_disable_slave_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> !master_mode);
endmodule

// File: tb/i2c_evt_status_test.sv
`timescale 1ns/100ps
module i2c_evt_status_test;
    logic clk = 1'b0;
    logic rst_n, scl_in, sda_in, periph_en, irq_en, ack_en, mst_req, mst_rel;
    logic drv_sda, byte_phase, ack_slot, is_tx, gcall_hit, rd_stb;
    logic [7:0] status;
    logic irq, master_mode;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    i2c_evt_status uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .periph_en(periph_en), .irq_en(irq_en), .ack_en(ack_en),
        .mst_req(mst_req), .mst_rel(mst_rel), .drv_sda(drv_sda),
        .byte_phase(byte_phase), .ack_slot(ack_slot), .is_tx(is_tx),
        .gcall_hit(gcall_hit), .rd_stb(rd_stb), .status(status),
        .irq(irq), .master_mode(master_mode));

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic s, input logic d);
        scl_in = s;
        sda_in = d;
        cyc(4);
    endtask

    task automatic clr();
        rd_stb = 1'b1;
        cyc(1);
        rd_stb = 1'b0;
    endtask

    task automatic pulse_req();
        mst_req = 1'b1;
        cyc(1);
        mst_req = 1'b0;
    endtask

    task automatic pulse_rel();
        mst_rel = 1'b1;
        cyc(1);
        mst_rel = 1'b0;
    endtask

    task automatic pulse_gc();
        gcall_hit = 1'b1;
        cyc(1);
        gcall_hit = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 mode", {7'd0, master_mode}, 8'h00);
    endtask

    task automatic t_af();
        ack_slot = 1'b1; is_tx = 1'b1;
        bus(1'b0, 1'b1);
        scl_in = 1'b1;
        cyc(2);
        chk("R3 not yet after two edges", status, 8'h00);
        cyc(1);
        chk("R3 R2 missing ack bit4", status, 8'h10);
        cyc(3);
        chk("R1 upper bits zero", {5'd0, status[7:5]}, 8'h00);
        bus(1'b0, 1'b1);
        ack_slot = 1'b0;
        clr();
        chk("R9 read clears", status, 8'h00);
    endtask

    task automatic t_arb();
        pulse_req();
        chk("R5 mode set", {7'd0, master_mode}, 8'h01);
        byte_phase = 1'b1; is_tx = 1'b1; drv_sda = 1'b1;
        bus(1'b0, 1'b0);
        scl_in = 1'b1;
        cyc(2);
        chk("R5 mode before edge", {7'd0, master_mode}, 8'h01);
        cyc(1);
        chk("R5 R2 arb bit2", status, 8'h04);
        chk("R5 back to slave", {7'd0, master_mode}, 8'h00);
        cyc(1);
        bus(1'b0, 1'b0);
        byte_phase = 1'b0;
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        clr();
    endtask

    task automatic t_ack_excl();
        pulse_req();
        is_tx = 1'b0; ack_slot = 1'b1; drv_sda = 1'b1;
        bus(1'b0, 1'b1);
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        chk("R6 no flag in rx ack slot", status, 8'h00);
        chk("R6 still master", {7'd0, master_mode}, 8'h01);
        bus(1'b0, 1'b0);
        ack_slot = 1'b0;
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        pulse_rel();
    endtask

    task automatic stop_seq();
        ack_slot = 1'b1;
        bus(1'b0, 1'b1);
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        ack_slot = 1'b0;
        bus(1'b1, 1'b1);
    endtask

    task automatic t_stop();
        ack_en = 1'b1; is_tx = 1'b0;
        stop_seq();
        chk("R4 R2 slave stop bit3", status, 8'h08);
        clr();
        ack_en = 1'b0;
        stop_seq();
        chk("R4 no stop flag without ack_en", status, 8'h00);
        ack_en = 1'b1;
        pulse_req();
        stop_seq();
        chk("R4 no stop flag in master", status, 8'h00);
        pulse_rel();
        ack_en = 1'b0;
    endtask

    task automatic t_berr();
        byte_phase = 1'b1;
        bus(1'b1, 1'b0);
        chk("R7 R2 start in byte bit1", status, 8'h02);
        clr();
        bus(1'b1, 1'b1);
        chk("R7 stop in byte", status, 8'h02);
        byte_phase = 1'b0;
        clr();
        chk("R7 cleared", status, 8'h00);
    endtask

    task automatic t_gcall();
        pulse_gc();
        chk("R8 R2 general call bit0", status, 8'h01);
        clr();
    endtask

    task automatic t_read_same();
        rd_stb = 1'b1; gcall_hit = 1'b1;
        cyc(1);
        rd_stb = 1'b0; gcall_hit = 1'b0;
        chk("R9 event alone under read kept", status, 8'h01);
        clr();
        byte_phase = 1'b1;
        bus(1'b1, 1'b0);
        byte_phase = 1'b0;
        bus(1'b0, 1'b0);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        chk("R9 bus error latched", status, 8'h02);
        rd_stb = 1'b1; gcall_hit = 1'b1;
        cyc(1);
        rd_stb = 1'b0; gcall_hit = 1'b0;
        chk("R9 read clears old, keeps new", status, 8'h01);
        clr();
    endtask

    task automatic t_disable();
        pulse_gc();
        pulse_req();
        periph_en = 1'b0;
        cyc(1);
        chk("R10 flags cleared", status, 8'h00);
        chk("R10 slave", {7'd0, master_mode}, 8'h00);
        pulse_gc();
        pulse_req();
        chk("R10 no set while off", status, 8'h00);
        chk("R10 no master while off", {7'd0, master_mode}, 8'h00);
        periph_en = 1'b1;
        cyc(1);
    endtask

    task automatic t_irq();
        irq_en = 1'b1;
        #1;
        chk("R11 no flag no irq", {7'd0, irq}, 8'h00);
        pulse_gc();
        chk("R11 irq with flag", {7'd0, irq}, 8'h01);
        irq_en = 1'b0;
        #1;
        chk("R11 masked", {7'd0, irq}, 8'h00);
        irq_en = 1'b1;
        clr();
        chk("R11 irq drops after read", {7'd0, irq}, 8'h00);
        irq_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; periph_en = 1'b0;
        irq_en = 1'b0; ack_en = 1'b0; mst_req = 1'b0; mst_rel = 1'b0;
        drv_sda = 1'b1; byte_phase = 1'b0; ack_slot = 1'b0; is_tx = 1'b0;
        gcall_hit = 1'b0; rd_stb = 1'b0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        periph_en = 1'b1;
        cyc(1);
        t_af();
        t_arb();
        t_ack_excl();
        t_stop();
        t_berr();
        t_gcall();
        t_read_same();
        t_disable();
        t_irq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule